// File: doc/BRIEF.md
# Pulse Accumulator with Gated-Time Mode

This block is a 16-bit pulse accumulator fed by a single input pin and set up through an 8-bit control register on a small byte-wide register port. In event mode it adds one to its count on each chosen edge of the pin. In gated mode it adds one on every 64th system clock while the pin is at a chosen level. It raises a flag on the trailing edge of the gating pulse.

One enable bit and one edge bit serve both modes. In event mode the edge bit picks the counting edge. In gated mode it picks the gating polarity, and the edge that ends the gating pulse is the same edge that event mode would count. This means a single edge detector drives both the count and the input flag. A counter rollover sets an overflow flag. Each flag can drive an interrupt output through its own enable. Software clears a flag by writing 1 to it.

Top module: `pulse_acc`

Register map (`bus_addr`): 0 is control, 1 is flags, 2 is the count high byte, 3 is the count low byte. Control bits: 7 always reads 0, 6 is enable, 5 is mode (0 event, 1 gated), 4 is edge select, 3:2 are clock-select storage, 1 is the overflow interrupt enable, 0 is the input interrupt enable. Flag bits: 1 is overflow, 0 is input.

## Requirements
- R1: After reset, the control register, both flags, the count and both interrupt outputs are all 0.
- R2: The control register can be written and read back at any time. Bit 7 always reads 0, so writing 0xFF reads back 0x7F.
- R3: While enable (control bit 6) is 0, the count holds its value and no flag is set, whatever the pin does.
- R4: In event mode (bit 5 = 0), edge select 0 counts falling edges and edge select 1 counts rising edges. Each pin transition is counted once, and the count changes by at most 1 per cycle.
- R5: In event mode, the input flag (flag bit 0) is set on every counted edge.
- R6: In gated mode with edge select 0, the count advances once per 64 clocks while the pin is high. A falling edge sets the input flag.
- R7: In gated mode with edge select 1, the count advances once per 64 clocks while the pin is low. A rising edge sets the input flag.
- R8: An increment from 0xFFFF to 0x0000 sets the overflow flag (flag bit 1).
- R9: `ovf_irq` is the overflow flag gated by control bit 1. `edge_irq` is the input flag gated by control bit 0.
- R10: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R11: The count can be written at any time: address 2 writes the high byte and address 3 writes the low byte. A write takes priority over an increment in the same cycle.
- R12: The divide-by-64 prescaler is held at zero while the block is disabled. After enabling, the first gated tick lands 64 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| ovf_irq | output | 1 | Overflow interrupt request |
| edge_irq | output | 1 | Input-edge interrupt request |

## Verification
The assertions check four things on every cycle: the count is frozen while the block is disabled, the count never changes by more than one step, a gated-mode increment happens only on a prescaler tick, and a rollover always leaves the overflow flag set. They also check that a set event always leaves its flag set and that control bit 7 reads as zero. Only the directed scenarios can show the rest. These are edge polarity in event mode, the exact count of ten after 650 gated clocks, the trailing-edge flag for each polarity, the first tick arriving exactly 64 clocks after enabling, and write-one-to-clear seen through the interrupt pins.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_irq,
  output logic       edge_irq
);
  localparam int PRESC_W = $clog2(PRESC_DIV);
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [6:0]         ctrl_q;
  logic               pin_meta, pin_sync, pin_prev;
  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   count;
  logic               ovf_flag, in_flag;

  wire en      = ctrl_q[6];
  wire gated   = ctrl_q[5];
  wire pol     = ctrl_q[4];
  wire ovf_ie  = ctrl_q[1];
  wire in_ie   = ctrl_q[0];

  wire rise     = pin_sync & ~pin_prev;
  wire fall     = ~pin_sync & pin_prev;
  wire sel_edge = pol ? rise : fall;
  wire level_ok = pol ? ~pin_sync : pin_sync;
  wire tick     = en && (presc == PRESC_LAST);
  wire inc      = en && (gated ? (tick && level_ok) : sel_edge);

  wire ctrl_wr  = bus_wr && (bus_addr == 2'd0);
  wire flag_wr  = bus_wr && (bus_addr == 2'd1);
  wire hi_wr    = bus_wr && (bus_addr == 2'd2);
  wire lo_wr    = bus_wr && (bus_addr == 2'd3);
  wire cnt_wr   = hi_wr || lo_wr;

  wire in_set   = en && sel_edge;
  wire ovf_set  = inc && !cnt_wr && (count == CNT_MAX);
  wire in_clr   = flag_wr && bus_wdata[0];
  wire ovf_clr  = flag_wr && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_meta <= 1'b0;
      pin_sync <= 1'b0;
      pin_prev <= 1'b0;
    end else begin
      pin_meta <= pin_in;
      pin_sync <= pin_meta;
      pin_prev <= pin_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc <= '0;
    else if (!en) presc <= '0;
    else presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (hi_wr) count[CNT_W-1 -: 8] <= bus_wdata;
    else if (lo_wr) count[7:0] <= bus_wdata;
    else if (inc) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      in_flag  <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag & ~ovf_clr) | ovf_set;
      in_flag  <= (in_flag & ~in_clr) | in_set;
    end
  end

  always_comb begin
    unique case (bus_addr)
      2'd0: bus_rdata = {1'b0, ctrl_q};
      2'd1: bus_rdata = {6'b0, ovf_flag, in_flag};
      2'd2: bus_rdata = count[CNT_W-1 -: 8];
      default: bus_rdata = count[7:0];
    endcase
  end

  assign ovf_irq  = ovf_flag & ovf_ie;
  assign edge_irq = in_flag & in_ie;
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        cnt_wr,
  input logic        en,
  input logic        gated,
  input logic [5:0]  presc,
  input logic [15:0] count,
  input logic        ovf_flag,
  input logic        in_flag,
  input logic        in_set
);
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count));

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == $past(count) + 16'd1));

  p_gated_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gated && !cnt_wr) |=> (count == $past(count) || $past(presc) == 6'd63));

  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 16'h0000 && $past(count) == 16'hFFFF && !$past(cnt_wr)) |-> ovf_flag);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_set |=> in_flag);

  p_presc_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> presc == 6'd0);

  p_bit7_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> !bus_rdata[7]);
endmodule

bind pulse_acc pulse_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cnt_wr(cnt_wr), .en(en), .gated(gated), .presc(presc), .count(count),
  .ovf_flag(ovf_flag), .in_flag(in_flag), .in_set(in_set)
);

// File: tb/pulse_acc_bench.sv
module pulse_acc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_irq, edge_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_acc u_pulse_acc (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic read_count(output logic [15:0] c);
    logic [7:0] h, l;
    rd(2'd2, h); rd(2'd3, l); c = {h, l};
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(int n, logic lvl);
    for (int i = 0; i < n; i++) begin
      pin_in = lvl; wait_clk(4);
      pin_in = ~lvl; wait_clk(4);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] c;
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 flags", d, 0);
    read_count(c); check("R1 count", c, 0);
    check("R1 irqs", {ovf_irq, edge_irq}, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 bit7 reads 0", d, 8'h7F);
    wr(2'd0, 8'h0C); rd(2'd0, d); check("R2 readback", d, 8'h0C);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d; logic [15:0] c;
    pulses(3, 1'b1); wait_clk(4);
    read_count(c); check("R3 count held", c, 0);
    rd(2'd1, d); check("R3 no flags", d, 0);
  endtask

  task automatic t_event_fall;
    logic [7:0] d; logic [15:0] c;
    wr(2'd0, 8'h40);
    pulses(3, 1'b1); wait_clk(4);
    read_count(c); check("R4 falling count", c, 3);
    rd(2'd1, d); check("R5 input flag", d, 8'h01);
    wr(2'd1, 8'h02); rd(2'd1, d); check("R10 write 0 keeps flag", d, 8'h01);
    wr(2'd1, 8'h01); rd(2'd1, d); check("R10 w1c clears", d, 8'h00);
  endtask

  task automatic t_event_rise;
    logic [15:0] c;
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wr(2'd0, 8'h51);
    check("R9 edge_irq idle", edge_irq, 0);
    pulses(2, 1'b1); wait_clk(4);
    read_count(c); check("R4 rising count", c, 2);
    check("R9 edge_irq set", edge_irq, 1);
    wr(2'd1, 8'h01); check("R9 edge_irq cleared", edge_irq, 0);
  endtask

  task automatic t_overflow;
    logic [7:0] d; logic [15:0] c;
    wr(2'd0, 8'h52);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    read_count(c); check("R11 count write", c, 16'hFFFF);
    pulses(1, 1'b1); wait_clk(4);
    read_count(c); check("R8 wrap to 0", c, 0);
    rd(2'd1, d); check("R8 ovf flag", d, 8'h03);
    check("R9 ovf_irq", ovf_irq, 1);
    check("R9 edge_irq masked", edge_irq, 0);
    wr(2'd1, 8'h03); check("R10 ovf cleared", ovf_irq, 0);
  endtask

  task automatic t_gated_high;
    logic [7:0] d; logic [15:0] c;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    pin_in = 1'b1; wait_clk(4);
    wr(2'd0, 8'h60);
    wait_clk(650);
    read_count(c); check("R6 ten ticks high", c, 10);
    rd(2'd1, d); check("R6 no flag while gating", d, 0);
    pin_in = 1'b0; wait_clk(100);
    read_count(c); check("R6 stopped when low", c, 10);
    rd(2'd1, d); check("R6 trailing fall flag", d, 8'h01);
  endtask

  task automatic t_gated_low;
    logic [7:0] d; logic [15:0] c;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wait_clk(4);
    wr(2'd0, 8'h70);
    wait_clk(63);
    read_count(c); check("R12 no tick before 64", c, 0);
    wait_clk(1);
    read_count(c); check("R12 first tick at 64", c, 1);
    wait_clk(586);
    read_count(c); check("R7 ten ticks low", c, 10);
    pin_in = 1'b1; wait_clk(10);
    rd(2'd1, d); check("R7 trailing rise flag", d, 8'h01);
    wait_clk(100);
    read_count(c); check("R7 stopped when high", c, 10);
    pin_in = 1'b0;
  endtask

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    t_reset;
    t_ctrl;
    t_disabled;
    t_event_fall;
    t_event_rise;
    t_overflow;
    t_gated_high;
    t_gated_low;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule